// File: doc/BRIEF.md
# Forwarding Store Miss Buffer

This block holds stores that missed in a cache that does not allocate lines on a write miss. Each pending store keeps its word address and its data. Stores enter through a valid/ready insert port and leave oldest first through a valid/ready remove port, which feeds a write-back queue outside this block.

While stores wait, a load can present its address on a combinational search port. If one or more pending stores target that word, the block returns the data of the most recent one, so the load sees the newest value without going to memory.

The order of operations within a cycle is fixed: a removal is applied first, then the search, then the insertion. A store leaving in a cycle is therefore not visible to that cycle's search, and a store arriving in a cycle is not visible to it either. The number of entries is a parameter.

Top module: `stmb_fwd_buf`

## Requirements
- R1: After synchronous reset the buffer is empty: `rem_valid` is 0, `ins_ready` is 1 and `srch_hit` is 0.
- R2: `ins_ready` is 0 exactly when DEPTH stores are held. An insert offered while `ins_ready` is 0 has no effect on the contents that are later drained.
- R3: `rem_valid` is 1 whenever at least one store is held, and `rem_addr`/`rem_data` show the oldest held store. A store is removed on a cycle where `rem_valid` and `rem_ready` are both 1.
- R4: Stores leave in the order they were accepted, including after the internal positions have wrapped around more than once.
- R5: When several held stores match the search address, `srch_data` is the data of the most recently accepted one, and `srch_hit` is 1.
- R6: When no held store matches, `srch_hit` is 0 and `srch_data` is all zeros.
- R7: A store removed in the current cycle does not take part in that cycle's search.
- R8: A store accepted in the current cycle does not take part in that cycle's search; it is found from the next cycle on.
- R9: A cycle that both accepts an insert and performs a removal leaves the number of held stores unchanged.
- R10: Matching compares every bit of the word address; addresses differing only in the top bit do not match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | A store miss is offered |
| ins_ready | output | 1 | Buffer can take a store this cycle |
| ins_addr | input | ADDR_W | Word address of the offered store |
| ins_data | input | DATA_W | Data of the offered store |
| rem_valid | output | 1 | Oldest store is available |
| rem_ready | input | 1 | Consumer takes the oldest store |
| rem_addr | output | ADDR_W | Word address of the oldest store |
| rem_data | output | DATA_W | Data of the oldest store |
| srch_addr | input | ADDR_W | Load word address to look up |
| srch_hit | output | 1 | Some held store matches |
| srch_data | output | DATA_W | Data of the youngest matching store, zero on no match |

## Verification
The bench aims at the same-cycle ordering: a search of an address whose only holder is being removed must miss, and a search of an address being inserted must miss until the next cycle; a design with the wrong order would forward stale or not-yet-accepted data. It loads duplicate addresses so that a search returning the oldest instead of the youngest match shows up as wrong data, and it pushes the pointers around the ring several times so a broken wrap reorders or loses stores. It also offers inserts into a full buffer and pairs inserts with removals near full, where a count that drifts would either drop a store or let the buffer overfill.

// File: rtl/stmb_pkg.sv
package stmb_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    typedef logic [ADDR_W-1:0] word_addr_t;
    typedef logic [DATA_W-1:0] word_data_t;

    typedef struct packed {
        word_addr_t addr;
        word_data_t data;
    } stmb_entry_t;

    // Position of the k-th oldest slot when the oldest sits at base.
    function automatic int ring_slot(input int base, input int k, input int depth);
        return (base + k) % depth;
    endfunction

endpackage

// File: rtl/stmb_ptr_ctrl.sv
module stmb_ptr_ctrl #(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ins_fire,
    input  logic             rem_fire,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (ins_fire) wr_ptr <= bump(wr_ptr);
            if (rem_fire) rd_ptr <= bump(rd_ptr);
            unique case ({ins_fire, rem_fire})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign full  = (count == FULL_CNT);
    assign empty = (count == '0);

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        int'(count) <= DEPTH);

    assert_pair_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (ins_fire && rem_fire) |=> (count == $past(count)));

    assert_ptr_gap_R4: assert property (@(posedge clk) disable iff (rst)
        ((int'(wr_ptr) - int'(rd_ptr) + DEPTH) % DEPTH) == (int'(count) % DEPTH));

endmodule

// File: rtl/stmb_entry_array.sv
module stmb_entry_array
    import stmb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [PTR_W-1:0]              wr_idx,
    input  stmb_entry_t                   wr_entry,
    input  logic                          clr_en,
    input  logic [PTR_W-1:0]              clr_idx,
    output stmb_entry_t [DEPTH-1:0]       slots,
    output logic [DEPTH-1:0]              slot_valid
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic hit_wr;
        logic hit_clr;
        assign hit_wr  = wr_en  && (int'(wr_idx)  == g);
        assign hit_clr = clr_en && (int'(clr_idx) == g);

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_valid[g] <= 1'b0;
                slots[g]      <= '0;
            end else if (hit_wr) begin
                slot_valid[g] <= 1'b1;
                slots[g]      <= wr_entry;
            end else if (hit_clr) begin
                slot_valid[g] <= 1'b0;
            end
        end
    end

    assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !(wr_en && (wr_idx == clr_idx))) |=> !slot_valid[$past(clr_idx)]);

    assert_fill_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> slot_valid[$past(wr_idx)]);

endmodule

// File: rtl/stmb_search.sv
module stmb_search
    import stmb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  stmb_entry_t [DEPTH-1:0] slots,
    input  logic [DEPTH-1:0]        slot_valid,
    input  logic [PTR_W-1:0]        oldest,
    input  logic                    drop_oldest,
    input  word_addr_t              key,
    output logic                    hit,
    output word_data_t              data
);
    // Walk oldest to youngest; a later match overwrites an earlier one.
    always_comb begin
        hit  = 1'b0;
        data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            int s;
            s = ring_slot(int'(oldest), k, DEPTH);
            if (slot_valid[s] && (slots[s].addr == key) && !(k == 0 && drop_oldest)) begin
                hit  = 1'b1;
                data = slots[s].data;
            end
        end
    end

endmodule

// File: rtl/stmb_fwd_buf.sv
module stmb_fwd_buf
    import stmb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_valid,
    output logic              ins_ready,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic [DATA_W-1:0] ins_data,
    output logic              rem_valid,
    input  logic              rem_ready,
    output logic [ADDR_W-1:0] rem_addr,
    output logic [DATA_W-1:0] rem_data,
    input  logic [ADDR_W-1:0] srch_addr,
    output logic              srch_hit,
    output logic [DATA_W-1:0] srch_data
);
    logic [PTR_W-1:0]        wr_ptr;
    logic [PTR_W-1:0]        rd_ptr;
    logic [CNT_W-1:0]        count;
    logic                    full;
    logic                    empty;
    logic                    ins_fire;
    logic                    rem_fire;
    stmb_entry_t [DEPTH-1:0] slots;
    logic [DEPTH-1:0]        slot_valid;
    stmb_entry_t             new_entry;

    assign ins_ready = !full;
    assign rem_valid = !empty;
    assign ins_fire  = ins_valid && ins_ready;
    assign rem_fire  = rem_valid && rem_ready;
    assign new_entry = '{addr: ins_addr, data: ins_data};

    stmb_ptr_ctrl #(.DEPTH(DEPTH)) i_ptr (
        .clk      (clk),
        .rst      (rst),
        .ins_fire (ins_fire),
        .rem_fire (rem_fire),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .count    (count),
        .full     (full),
        .empty    (empty)
    );

    stmb_entry_array #(.DEPTH(DEPTH)) i_arr (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (ins_fire),
        .wr_idx     (wr_ptr),
        .wr_entry   (new_entry),
        .clr_en     (rem_fire),
        .clr_idx    (rd_ptr),
        .slots      (slots),
        .slot_valid (slot_valid)
    );

    assign rem_addr = slots[rd_ptr].addr;
    assign rem_data = slots[rd_ptr].data;

    stmb_search #(.DEPTH(DEPTH)) i_srch (
        .slots       (slots),
        .slot_valid  (slot_valid),
        .oldest      (rd_ptr),
        .drop_oldest (rem_fire),
        .key         (srch_addr),
        .hit         (srch_hit),
        .data        (srch_data)
    );

    assert_valid_tally_R3: assert property (@(posedge clk) disable iff (rst)
        $countones(slot_valid) == int'(count));

    assert_head_valid_R3: assert property (@(posedge clk) disable iff (rst)
        rem_valid |-> slot_valid[rd_ptr]);

    assert_hit_source_R5: assert property (@(posedge clk) disable iff (rst)
        srch_hit |-> (slot_valid != '0));

    assert_miss_zero_R6: assert property (@(posedge clk) disable iff (rst)
        !srch_hit |-> (srch_data == '0));

endmodule

// File: tb/test_stmb_fwd_buf.sv
`timescale 1ns/1ps
module test_stmb_fwd_buf;
    import stmb_pkg::*;

    localparam int DEPTH = 4;

    logic              clk = 1'b0;
    logic              rst;
    logic              ins_valid;
    logic              ins_ready;
    logic [ADDR_W-1:0] ins_addr;
    logic [DATA_W-1:0] ins_data;
    logic              rem_valid;
    logic              rem_ready;
    logic [ADDR_W-1:0] rem_addr;
    logic [DATA_W-1:0] rem_data;
    logic [ADDR_W-1:0] srch_addr;
    logic              srch_hit;
    logic [DATA_W-1:0] srch_data;

    always #10 clk = ~clk;

    stmb_fwd_buf #(.DEPTH(DEPTH)) i_stmb_fwd_buf (
        .clk(clk), .rst(rst),
        .ins_valid(ins_valid), .ins_ready(ins_ready),
        .ins_addr(ins_addr), .ins_data(ins_data),
        .rem_valid(rem_valid), .rem_ready(rem_ready),
        .rem_addr(rem_addr), .rem_data(rem_data),
        .srch_addr(srch_addr), .srch_hit(srch_hit), .srch_data(srch_data)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    stmb_entry_t exp_q[$];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever the design hands out a store.
    always @(posedge clk) begin
        if (!rst && rem_valid && rem_ready) begin
            if (exp_q.size() == 0) begin
                chk(0, "R3 remove from empty model", 64'(rem_addr), 0);
            end else begin
                chk(rem_addr == exp_q[0].addr, "R3/R4 remove addr", 64'(rem_addr), 64'(exp_q[0].addr));
                chk(rem_data == exp_q[0].data, "R3/R4 remove data", 64'(rem_data), 64'(exp_q[0].data));
                void'(exp_q.pop_front());
            end
        end
    end

    // Driver: one cycle of stimulus with checks of ready, valid and search.
    task automatic step(input bit iv, input word_addr_t ia, input word_data_t id,
                        input bit rr, input word_addr_t sa, input string tag);
        bit         e_hit;
        word_data_t e_data;
        bit         e_rdy;
        int         first;
        @(negedge clk);
        ins_valid = iv; ins_addr = ia; ins_data = id;
        rem_ready = rr; srch_addr = sa;
        #2;
        e_rdy = (exp_q.size() < DEPTH);
        chk(ins_ready == e_rdy, {"R2 ins_ready ", tag}, 64'(ins_ready), 64'(e_rdy));
        chk(rem_valid == (exp_q.size() > 0), {"R3 rem_valid ", tag}, 64'(rem_valid), 64'(exp_q.size() > 0));
        e_hit = 0; e_data = '0;
        first = (rr && exp_q.size() > 0) ? 1 : 0;
        for (int k = first; k < exp_q.size(); k++) begin
            if (exp_q[k].addr == sa) begin
                e_hit = 1; e_data = exp_q[k].data;
            end
        end
        chk(srch_hit == e_hit, {"srch_hit ", tag}, 64'(srch_hit), 64'(e_hit));
        chk(srch_data == e_data, {"srch_data ", tag}, 64'(srch_data), 64'(e_data));
        if (iv && e_rdy) exp_q.push_back('{addr: ia, data: id});
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1; ins_valid = 0; ins_addr = '0; ins_data = '0; rem_ready = 0; srch_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #2;
        chk(rem_valid == 0, "R1 reset rem_valid", 64'(rem_valid), 0);
        chk(ins_ready == 1, "R1 reset ins_ready", 64'(ins_ready), 1);
        chk(srch_hit == 0,  "R1 reset srch_hit", 64'(srch_hit), 0);

        // R8: insert 0x100 and search it in the same cycle: miss, then hit.
        step(1, 32'h100, 32'hA0, 0, 32'h100, "R8 same-cycle insert");
        step(1, 32'h104, 32'hA1, 0, 32'h100, "R8 next cycle");
        // R5: duplicate address, youngest wins.
        step(1, 32'h100, 32'hB0, 0, 32'h104, "R5 setup");
        step(0, 32'h0,   32'h0,  0, 32'h100, "R5 youngest");
        // R6: no match.
        step(0, 32'h0, 32'h0, 0, 32'h200, "R6 miss");
        // R10: top bit differs.
        step(0, 32'h0, 32'h0, 0, 32'h8000_0104, "R10 full compare");
        // Fill to full, R2: offer while full is ignored.
        step(1, 32'h10C, 32'hC0, 0, 32'h10C, "R2 fill");
        step(1, 32'h999, 32'hDEAD, 0, 32'h999, "R2 full offer");
        step(1, 32'h999, 32'hDEAD, 0, 32'h999, "R2 full offer again");
        // R7: head 0x100 (A0) leaves; only youngest 0x100 copy B0 visible.
        step(0, 32'h0, 32'h0, 1, 32'h100, "R7 remove head dup");
        // Head now 0x104 (only holder): removing it hides it.
        step(0, 32'h0, 32'h0, 1, 32'h104, "R7 remove sole holder");
        // R9: 2 held; insert+remove pairs keep count.
        step(1, 32'h110, 32'hD0, 0, 32'h0, "R9 to three");
        step(1, 32'h114, 32'hD1, 1, 32'h114, "R9 pair");
        step(1, 32'h118, 32'hD2, 0, 32'h118, "R9 fill after pair");
        step(1, 32'h11C, 32'hD3, 0, 32'h118, "R9 full refuse");
        // Drain everything.
        for (int i = 0; i < DEPTH + 1; i++) step(0, 32'h0, 32'h0, 1, 32'h118, "R3 drain");
        // R4: many wraps with mixed traffic.
        for (int i = 0; i < 40; i++) begin
            step(1, 32'h400 + 32'(i % 3), 32'h5000 + 32'(i), (i % 3) != 0, 32'h400 + 32'(i % 3), "R4 wrap traffic");
        end
        for (int i = 0; i < DEPTH + 1; i++) step(0, 32'h0, 32'h0, 1, 32'h401, "R4 final drain");
        step(0, 32'h0, 32'h0, 0, 32'h401, "R1 empty again");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule